// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level page structure held in ordinary memory. A requester presents a linear address with a write flag and a user flag. The walker then reads one directory entry and one table entry through a single word-wide memory port. It checks the present, user and writable bits of both entries. If all checks pass, it returns the page frame joined with the page offset. If a check fails, it reports a page fault instead, with a small fault code, and the faulting linear address is held in a fault-address register.

On a successful walk the walker also keeps the accessed and dirty bookkeeping in memory up to date. It writes an entry back only when one of those bits actually changes, and always handles the directory entry before the table entry. When paging is switched off, the request completes at once with the linear address as the physical address, and the memory port stays silent.

The controller is one state machine with these states:
- `S_IDLE`: ready, waiting for a request.
- `S_RD_DIR`: reading the directory entry.
- `S_CHK_DIR`: checking the directory entry.
- `S_RD_TBL`: reading the table entry.
- `S_CHK_TBL`: checking the table entry.
- `S_WB_DIR`: writing the directory entry back.
- `S_WB_TBL`: writing the table entry back.
- `S_FINISH`: done pulse with the physical address.
- `S_FAULT`: done pulse with a fault.

Transitions:
- `S_IDLE` goes to `S_RD_DIR` on an accepted request with paging on, or to `S_FINISH` with paging off.
- A read state advances to its check state on `mem_ack`.
- `S_CHK_DIR` goes to `S_FAULT` on a failed check, else to `S_RD_TBL`.
- `S_CHK_TBL` goes to `S_FAULT` on a failed check, else to `S_WB_DIR` if the directory accessed bit is clear, else to `S_WB_TBL` if the table entry needs an update, else to `S_FINISH`.
- `S_WB_DIR` goes on `mem_ack` to `S_WB_TBL` or `S_FINISH`.
- `S_WB_TBL` goes on `mem_ack` to `S_FINISH`.
- `S_FINISH` and `S_FAULT` return to `S_IDLE`.

Top module: `xlate_walker`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Every accepted request produces exactly one single-cycle `done` pulse.
- R2: A request accepted while `pg_enable` is 0 completes with `done_fault`=0 and `done_phys` equal to the linear address, and makes no memory access.
- R3: The directory entry is read from address {`dir_base`, linear[31:22], 2'b00}. The table entry is read from address {directory entry[31:12], linear[21:12], 2'b00}.
- R4: A successful walk returns `done_phys` = {table entry[31:12], linear[11:0]}.
- R5: An entry whose present bit (bit 0) is 0, at either level, ends the walk with `done_fault`=1. A fault at the directory level makes no table read.
- R6: For a user request (`req_user`=1), a fault is raised by an entry at either level with user bit (bit 2) equal to 0. It is also raised by a user write to an entry with writable bit (bit 1) equal to 0. Supervisor requests skip both checks.
- R7: During a fault `done`, `fault_code` = {request user flag, request write flag, present bit of the failing entry}: bit 2 user, bit 1 write, bit 0 present.
- R8: `fault_addr` resets to 0. It takes the faulting linear address so that it is valid during the fault `done` pulse. It keeps its value through all other requests.
- R9: After both checks pass, the directory entry is written back with accessed (bit 5) set, but only if that bit was clear; its bit 6 is never altered. After that, the table entry is written with accessed set, and with dirty (bit 6) set on a write, but only if a bit changes. A faulting walk writes nothing.
- R10: The memory port holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ack`. Read data is taken in the cycle in which `mem_ack` is high.
- R11: During and right after reset, `req_ready`=1, `done`=0, `mem_req`=0 and `fault_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_enable | input | 1 | Paging on (1) or pass-through (0) |
| dir_base | input | 20 | Page frame of the directory; its low 12 address bits are zero |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request comes from user level |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Completion is a page fault |
| done_phys | output | 32 | Physical address, valid with `done` and no fault |
| fault_code | output | 3 | {user, write, present} of the last fault |
| fault_addr | output | 32 | Linear address of the last fault |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Word address of the memory access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The bench builds the walker with its defaults: 32-bit addresses and a 12-bit page offset, which gives two 10-bit index fields. It places four directory entries and eight table entries per table at full 32-bit addresses, plus unpopulated slots that read as zero. Random requests then reach every combination of present, user, writable, accessed and dirty bits at both levels, mixed with paging-off requests. Directed cases pin down the supervisor override, the no-write-back path, and the holding of the fault address across good walks.

// File: rtl/xw_pkg.sv
package xw_pkg;
    // Bit positions inside a directory or table entry; the walker decodes these.
    localparam int unsigned ENT_PRESENT  = 0;
    localparam int unsigned ENT_WRITABLE = 1;
    localparam int unsigned ENT_USER     = 2;
    localparam int unsigned ENT_ACCESSED = 5;
    localparam int unsigned ENT_DIRTY    = 6;

    localparam int unsigned CODE_W = 3;   // {user, write, present}
    localparam int unsigned LEVELS = 2;   // directory, table

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_DIR,
        S_CHK_DIR,
        S_RD_TBL,
        S_CHK_TBL,
        S_WB_DIR,
        S_WB_TBL,
        S_FINISH,
        S_FAULT
    } walk_state_t;
endpackage

// File: rtl/xw_addr_gen.sv
// Forms the two entry addresses and the final physical address.
// Entries are 4 bytes, so one page holds 2**(OFF_W-2) of them.
module xw_addr_gen #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 12
) (
    input  logic [ADDR_W-OFF_W-1:0] base_frame,
    input  logic [ADDR_W-1:0]       lin,
    input  logic [ADDR_W-OFF_W-1:0] dir_frame,
    input  logic [ADDR_W-OFF_W-1:0] tbl_frame,
    output logic [ADDR_W-1:0]       dir_addr,
    output logic [ADDR_W-1:0]       tbl_addr,
    output logic [ADDR_W-1:0]       phys
);
    localparam int unsigned IDX_W  = OFF_W - 2;
    localparam int unsigned DIR_LO = OFF_W + IDX_W;

    always_comb begin
        dir_addr = {base_frame, lin[ADDR_W-1:DIR_LO], 2'b00};
        tbl_addr = {dir_frame,  lin[DIR_LO-1:OFF_W],  2'b00};
        phys     = {tbl_frame,  lin[OFF_W-1:0]};
    end
endmodule

// File: rtl/xw_perm_check.sv
// Permission check of one entry against the request flags.
module xw_perm_check (
    input  logic present,
    input  logic user_ok,
    input  logic writable,
    input  logic req_user,
    input  logic req_write,
    output logic fail
);
    always_comb begin
        fail = !present || (req_user && (!user_ok || (req_write && !writable)));
    end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 12   // ADDR_W must equal OFF_W + 2*(OFF_W-2)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pg_enable,
    input  logic [ADDR_W-OFF_W-1:0]   dir_base,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [ADDR_W-1:0]         req_lin,
    input  logic                      req_write,
    input  logic                      req_user,
    output logic                      done,
    output logic                      done_fault,
    output logic [ADDR_W-1:0]         done_phys,
    output logic [xw_pkg::CODE_W-1:0] fault_code,
    output logic [ADDR_W-1:0]         fault_addr,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [ADDR_W-1:0]         mem_wdata,
    input  logic                      mem_ack,
    input  logic [ADDR_W-1:0]         mem_rdata
);
    import xw_pkg::*;

    localparam int unsigned FRAME_W = ADDR_W - OFF_W;
    localparam logic [ADDR_W-1:0] ACC_MASK = ADDR_W'(1) << ENT_ACCESSED;
    localparam logic [ADDR_W-1:0] DRT_MASK = ADDR_W'(1) << ENT_DIRTY;

    walk_state_t state, nxt;

    logic [ADDR_W-1:0] lin_q, pde_q, pte_q, fault_addr_q;
    logic [CODE_W-1:0] fault_code_q;
    logic              wr_q, usr_q, byp_q;

    logic [ADDR_W-1:0] dir_addr, tbl_addr, phys;
    logic [ADDR_W-1:0] lvl_ent [LEVELS];
    logic [LEVELS-1:0] lvl_fail;
    logic              tbl_upd;

    // ---------------- address formation ----------------
    xw_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
        .base_frame (dir_base),
        .lin        (lin_q),
        .dir_frame  (pde_q[ADDR_W-1:OFF_W]),
        .tbl_frame  (pte_q[ADDR_W-1:OFF_W]),
        .dir_addr   (dir_addr),
        .tbl_addr   (tbl_addr),
        .phys       (phys)
    );

    // ---------------- per-level permission checks ----------------
    assign lvl_ent[0] = pde_q;
    assign lvl_ent[1] = pte_q;

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
        xw_perm_check u_chk (
            .present   (lvl_ent[lv][ENT_PRESENT]),
            .user_ok   (lvl_ent[lv][ENT_USER]),
            .writable  (lvl_ent[lv][ENT_WRITABLE]),
            .req_user  (usr_q),
            .req_write (wr_q),
            .fail      (lvl_fail[lv])
        );
    end

    assign tbl_upd = !pte_q[ENT_ACCESSED] || (wr_q && !pte_q[ENT_DIRTY]);

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (req_valid) nxt = pg_enable ? S_RD_DIR : S_FINISH;
            S_RD_DIR:  if (mem_ack) nxt = S_CHK_DIR;
            S_CHK_DIR: nxt = lvl_fail[0] ? S_FAULT : S_RD_TBL;
            S_RD_TBL:  if (mem_ack) nxt = S_CHK_TBL;
            S_CHK_TBL: begin
                if (lvl_fail[1])                nxt = S_FAULT;
                else if (!pde_q[ENT_ACCESSED])  nxt = S_WB_DIR;
                else if (tbl_upd)               nxt = S_WB_TBL;
                else                            nxt = S_FINISH;
            end
            S_WB_DIR:  if (mem_ack) nxt = tbl_upd ? S_WB_TBL : S_FINISH;
            S_WB_TBL:  if (mem_ack) nxt = S_FINISH;
            S_FINISH:  nxt = S_IDLE;
            S_FAULT:   nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // ---------------- walk datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q        <= '0;
            wr_q         <= 1'b0;
            usr_q        <= 1'b0;
            byp_q        <= 1'b0;
            pde_q        <= '0;
            pte_q        <= '0;
            fault_addr_q <= '0;
            fault_code_q <= '0;
        end else begin
            if (state == S_IDLE && req_valid) begin
                lin_q <= req_lin;
                wr_q  <= req_write;
                usr_q <= req_user;
                byp_q <= !pg_enable;
            end
            if (state == S_RD_DIR && mem_ack) pde_q <= mem_rdata;
            if (state == S_RD_TBL && mem_ack) pte_q <= mem_rdata;
            if (state == S_CHK_DIR && lvl_fail[0]) begin
                fault_addr_q <= lin_q;
                fault_code_q <= {usr_q, wr_q, pde_q[ENT_PRESENT]};
            end
            if (state == S_CHK_TBL && lvl_fail[1]) begin
                fault_addr_q <= lin_q;
                fault_code_q <= {usr_q, wr_q, pte_q[ENT_PRESENT]};
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready  = (state == S_IDLE);
        done       = (state == S_FINISH) || (state == S_FAULT);
        done_fault = (state == S_FAULT);
        done_phys  = '0;
        fault_code = fault_code_q;
        fault_addr = fault_addr_q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        unique case (state)
            S_RD_DIR: begin
                mem_req  = 1'b1;
                mem_addr = dir_addr;
            end
            S_RD_TBL: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
            end
            S_WB_DIR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_addr;
                mem_wdata = pde_q | ACC_MASK;
            end
            S_WB_TBL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_addr;
                mem_wdata = pte_q | ACC_MASK | (wr_q ? DRT_MASK : '0);
            end
            S_FINISH:  done_phys = byp_q ? lin_q : phys;
            S_IDLE, S_CHK_DIR, S_CHK_TBL, S_FAULT: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/xw_checker.sv
module xw_checker #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic              done_fault,
    input logic [ADDR_W-1:0] fault_addr,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic              mem_ack
);
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    a_r1_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_no_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !done);

    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    a_r8_fault_addr_moves_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_addr) |-> done && done_fault);

    a_r9_writeback_sets_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[5]);

    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));
endmodule

bind xlate_walker xw_checker #(.ADDR_W(ADDR_W)) u_xw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .done       (done),
    .done_fault (done_fault),
    .fault_addr (fault_addr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack)
);

// File: tb/test_xlate_walker.sv
module test_xlate_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_enable = 1'b1;
    logic [19:0] dir_base = 20'h00100;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        done, done_fault;
    logic [31:0] done_phys;
    logic [2:0]  fault_code;
    logic [31:0] fault_addr;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    xlate_walker i_xlate_walker (
        .clk(clk), .rst_n(rst_n), .pg_enable(pg_enable), .dir_base(dir_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
        .req_write(req_write), .req_user(req_user), .done(done),
        .done_fault(done_fault), .done_phys(done_phys), .fault_code(fault_code),
        .fault_addr(fault_addr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem [logic [31:0]];
    logic [31:0] acc_log [8];
    int          nacc = 0;
    int          nwr  = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= rd(mem_addr);
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    nwr = nwr + 1;
                end
                if (nacc < 8) acc_log[nacc] = mem_addr;
                nacc = nacc + 1;
            end
        end
    end

    // ---------------- check helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ent(input logic [19:0] frame, input logic p,
                                        input logic rw, input logic us,
                                        input logic a, input logic d);
        return {frame, 5'b0, d, a, 2'b0, us, rw, p};
    endfunction

    function automatic logic bad(input logic [31:0] e, input logic usr, input logic wr);
        return !e[0] || (usr && (!e[2] || (wr && !e[1])));
    endfunction

    logic [31:0] exp_fa = 32'h0;

    // ---------------- one translation with prediction ----------------
    task automatic xlate(input logic [31:0] lin, input logic wr, input logic usr,
                         input logic pg);
        logic [31:0] pa, ta, pde, pte, npde, npte, ephys;
        logic        efault, pde_wb, pte_wb;
        logic [2:0]  ecode;
        int          eacc, ewr, w;
        pa = {dir_base, lin[31:22], 2'b00};
        pde = rd(pa);
        ta = {pde[31:12], lin[21:12], 2'b00};
        pte = rd(ta);
        efault = 1'b0; ecode = 3'b0; ephys = 32'h0;
        pde_wb = 1'b0; pte_wb = 1'b0;
        npde = pde | 32'h20;
        npte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (!pg) begin
            ephys = lin; eacc = 0;
        end else if (bad(pde, usr, wr)) begin
            efault = 1'b1; ecode = {usr, wr, pde[0]}; eacc = 1;
        end else if (bad(pte, usr, wr)) begin
            efault = 1'b1; ecode = {usr, wr, pte[0]}; eacc = 2;
        end else begin
            ephys  = {pte[31:12], lin[11:0]};
            pde_wb = (npde != pde);
            pte_wb = (npte != pte);
            eacc   = 2 + int'(pde_wb) + int'(pte_wb);
        end
        if (efault) exp_fa = lin;
        ewr = int'(pde_wb) + int'(pte_wb);

        @(negedge clk);
        chk("R1 ready before request", {31'b0, req_ready}, 32'h1);
        nacc = 0; nwr = 0;
        pg_enable = pg; req_lin = lin; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (!done && w < 40);
        chk("R1 done pulse seen", {31'b0, done}, 32'h1);
        chk(pg ? "R5 R6 fault flag" : "R2 bypass fault flag", {31'b0, done_fault}, {31'b0, efault});
        if (efault) begin
            chk("R7 fault code", {29'b0, fault_code}, {29'b0, ecode});
            chk("R8 fault address", fault_addr, exp_fa);
        end else begin
            chk(pg ? "R4 physical address" : "R2 bypass address", done_phys, ephys);
            chk("R8 fault address held", fault_addr, exp_fa);
        end
        @(negedge clk);
        chk("R1 single done pulse", {31'b0, done}, 32'h0);
        chk(pg ? "R9 R10 access count" : "R2 no memory access", 32'(nacc), 32'(eacc));
        chk("R9 write count", 32'(nwr), 32'(ewr));
        if (pg) chk("R3 directory entry address", acc_log[0], pa);
        if (eacc >= 2) chk("R3 table entry address", acc_log[1], ta);
        if (pde_wb) begin
            chk("R9 directory written first", acc_log[2], pa);
            chk("R9 directory accessed set, bit6 kept", rd(pa), npde);
        end
        if (pte_wb) begin
            chk("R9 table written", acc_log[pde_wb ? 3 : 2], ta);
            chk("R9 table accessed and dirty", rd(ta), npte);
        end
        if (!pde_wb && !efault && pg) chk("R9 directory untouched", rd(pa), pde);
        if (!pte_wb && eacc >= 2) chk("R9 table untouched", rd(ta), pte);
    endtask

    task automatic fill_tables();
        for (int d = 0; d < 4; d++) begin
            mem[{20'h00100, 10'(d), 2'b00}] = ent(20'h00200 + 20'(d),
                ($urandom % 8) != 0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            for (int t = 0; t < 8; t++)
                mem[{20'h00200 + 20'(d), 10'(t), 2'b00}] = ent(20'($urandom),
                    ($urandom % 8) != 0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL R1 watchdog actual=%0d expected<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R11 ready in reset", {31'b0, req_ready}, 32'h1);
        chk("R11 no done in reset", {31'b0, done}, 32'h0);
        chk("R11 no memory request in reset", {31'b0, mem_req}, 32'h0);
        chk("R11 fault address reset", fault_addr, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after reset", {30'b0, req_ready, mem_req}, 32'h2);

        // R2: paging off
        xlate(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0);
        // R5: directory not present (slot 9 empty)
        xlate({10'd9, 10'd0, 12'h123}, 1'b0, 1'b0, 1'b1);
        // R5: table entry not present
        mem[{20'h00100, 10'd0, 2'b00}] = ent(20'h00200, 1, 1, 1, 0, 0);
        mem[{20'h00200, 10'd1, 2'b00}] = ent(20'hABCDE, 0, 1, 1, 0, 0);
        xlate({10'd0, 10'd1, 12'h456}, 1'b1, 1'b0, 1'b1);
        // R6: user on supervisor page faults, supervisor passes
        mem[{20'h00200, 10'd2, 2'b00}] = ent(20'h12345, 1, 1, 0, 0, 0);
        xlate({10'd0, 10'd2, 12'h010}, 1'b0, 1'b1, 1'b1);
        xlate({10'd0, 10'd2, 12'h020}, 1'b0, 1'b0, 1'b1);
        // R6: user write to read-only faults, supervisor write passes and sets dirty
        mem[{20'h00200, 10'd3, 2'b00}] = ent(20'h0FEDC, 1, 0, 1, 0, 0);
        xlate({10'd0, 10'd3, 12'hFFF}, 1'b1, 1'b1, 1'b1);
        xlate({10'd0, 10'd3, 12'hFFC}, 1'b1, 1'b0, 1'b1);
        // R9: everything already set, no writes
        xlate({10'd0, 10'd3, 12'h000}, 1'b1, 1'b0, 1'b1);
        // R6: user read-only directory blocks user write
        mem[{20'h00100, 10'd1, 2'b00}] = ent(20'h00201, 1, 0, 1, 1, 1);
        mem[{20'h00201, 10'd0, 2'b00}] = ent(20'h55555, 1, 1, 1, 1, 1);
        xlate({10'd1, 10'd0, 12'h777}, 1'b1, 1'b1, 1'b1);
        xlate({10'd1, 10'd0, 12'h778}, 1'b0, 1'b1, 1'b1);

        // random mix
        for (int n = 0; n < 400; n++) begin
            if (n % 16 == 0) fill_tables();
            xlate({10'($urandom % 5), 10'($urandom % 9), 12'($urandom)},
                  1'($urandom), 1'($urandom), ($urandom % 10) != 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule